// File: doc/BRIEF.md
# Scrambled-Memory Control and Status Register Block

This block is the register front end of a scrambled on-chip memory. A simple 32-bit register bus reads and writes a small set of word-aligned registers. These registers hold status, write locks, request controls, a key-rotation acknowledgement and two 4-bit enables. Software uses the control register to ask for a fresh scrambling key and for a memory initialisation. A sequencer turns these asks into request/acknowledge handshakes with an external key provider and an external initialiser.

While no valid key is held, the block asserts a memory-block output. It does the same for ever after an escalation. Escalation also wipes the key state back to its defaults. Error pulses from outside checkers latch into sticky status bits and drive a fatal alert.

The sequencer has four states:
- `ST_IDLE`: no request outstanding.
- `ST_KEY`: a key request is held towards the provider.
- `ST_INIT`: an initialisation request is held towards the initialiser.
- `ST_DEAD`: terminal state after escalation.

Its transitions are:
- `ST_IDLE` to `ST_KEY`: a control write with the renew bit set.
- `ST_IDLE` to `ST_INIT`: a control write with only the init bit set.
- `ST_KEY` to `ST_INIT`: a key acknowledge arrives while an init is queued.
- `ST_KEY` to `ST_IDLE`: a key acknowledge arrives with no init queued.
- `ST_INIT` to `ST_IDLE`: an init acknowledge arrives.
- Any state to `ST_DEAD`: escalation.

Top module: `memscr_regs`

Multibit true is the 4-bit pattern 4'h6 and multibit false is 4'h9. The byte map is:

| Address | Register |
|---|---|
| 0x00 | alert test |
| 0x04 | status |
| 0x08 | execute lock |
| 0x0C | execute enable |
| 0x10 | control lock |
| 0x14 | control |
| 0x18 | key-rotated |
| 0x1C | readback lock |
| 0x20 | readback enable |

Status bit positions:
- bit 0: bus-integrity error
- bit 1: init-counter error
- bit 2: escalated
- bit 3: key valid
- bit 4: seed valid
- bit 5: init done
- bit 6: readback error
- bit 7: memory multi-bit error

## Requirements
- R1: After reset the registers read as follows: status 0, all three locks 1, execute enable 4'h9, readback enable 4'h9, key-rotated 4'h9, alert test 0 and control 0. In the same state `mem_block` is 1 and neither request output is active.
- R2: A write with bit 0 equal to 0 clears a lock, and a write of 1 never sets it again. While a lock is 0, writes to the register it guards are ignored: execute lock guards 0x0C, control lock guards 0x14, readback lock guards 0x20. While unlocked, any 4-bit value written to an enable reads back unchanged.
- R3: A control write with bit 0 set in `ST_IDLE` raises `key_req` from the next cycle until a `key_ack` cycle and clears status bit 3. On the acknowledge, bit 3 becomes 1 and bit 4 takes `key_seed_ok`.
- R4: A control write with both bits set runs the key request first. `init_req` rises only in the cycle after `key_ack`, and the two requests are never active together.
- R5: A renew write has no effect while a key request or an initialisation is outstanding. An init write has no effect while an init is outstanding or already queued.
- R6: `mem_block` is 1 whenever status bit 3 is 0 or status bit 2 is 1.
- R7: Key-rotated becomes 4'h6 when a key is acknowledged. A write of 4'h6 changes it to 4'h9. Writes of any other value leave it unchanged.
- R8: An `escalate` pulse sets status bit 2 and clears bits 3 and 4. It returns key-rotated to 4'h9, ends any request, and holds `mem_block` at 1 until reset.
- R9: The pulses `err_bus_integ`, `err_init_cnt`, `err_readback` and `err_mem_multibit` set status bits 0, 1, 6 and 7 respectively. These bits are sticky, and `fatal_alert` stays 1 from the next cycle on.
- R10: A write of 1 to bit 0 of 0x00 gives exactly one cycle of `fatal_alert` in the following cycle.
- R11: Reserved bits read 0, and writes to the status register have no effect.
- R12: Starting an initialisation clears status bit 5, and `init_ack` in `ST_INIT` sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for `req_addr`, combinational |
| key_req | output | 1 | Key request to the provider |
| key_ack | input | 1 | One-cycle key completion |
| key_seed_ok | input | 1 | Key came from a provisioned seed; sampled with `key_ack` |
| init_req | output | 1 | Initialisation request |
| init_ack | input | 1 | One-cycle initialisation completion |
| escalate | input | 1 | Escalation pulse |
| err_bus_integ | input | 1 | Bus-integrity fault pulse |
| err_init_cnt | input | 1 | Init-counter fault pulse |
| err_readback | input | 1 | Readback mismatch pulse |
| err_mem_multibit | input | 1 | Memory multi-bit fault pulse |
| mem_block | output | 1 | Memory transactions must be refused |
| fatal_alert | output | 1 | Fatal alert level, including test pulses |
| exec_en | output | 4 | Execute enable value |
| readback_en | output | 4 | Readback enable value |

## Verification
The assertions assume that `key_ack` and `init_ack` are single-cycle pulses given only while the matching request is high. They also assume that `escalate` and the error inputs are low during reset. The bench drives every input on the falling edge and raises acknowledges only after it has seen the matching request. It pulses each error and escalation exactly once, and it keeps all inputs at 0 throughout reset, so the stimulus stays inside these assumptions.

// File: rtl/memscr_pkg.sv
package memscr_pkg;
    parameter int ADDR_W = 6;
    parameter int DATA_W = 32;
    parameter int MB_W   = 4;
    parameter int N_LOCK = 3;

    localparam logic [MB_W-1:0] MB_TRUE  = 4'h6;
    localparam logic [MB_W-1:0] MB_FALSE = 4'h9;

    localparam logic [ADDR_W-1:0] A_ALERT  = 6'h00;
    localparam logic [ADDR_W-1:0] A_STATUS = 6'h04;
    localparam logic [ADDR_W-1:0] A_XLOCK  = 6'h08;
    localparam logic [ADDR_W-1:0] A_XEN    = 6'h0C;
    localparam logic [ADDR_W-1:0] A_CLOCK  = 6'h10;
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h14;
    localparam logic [ADDR_W-1:0] A_ROT    = 6'h18;
    localparam logic [ADDR_W-1:0] A_RLOCK  = 6'h1C;
    localparam logic [ADDR_W-1:0] A_REN    = 6'h20;

    // lock index 0: execute, 1: control, 2: readback
    localparam logic [ADDR_W-1:0] LOCK_ADDR [N_LOCK] = '{A_XLOCK, A_CLOCK, A_RLOCK};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEY  = 2'd1,
        ST_INIT = 2'd2,
        ST_DEAD = 2'd3
    } seq_state_e;
endpackage

// File: rtl/memscr_lock.sv
module memscr_lock
    import memscr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    output logic              lock_open
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock_open <= 1'b1;
        else if (wr_en && wr_addr == MY_ADDR && !wr_bit)
            lock_open <= 1'b0;
    end
endmodule

// File: rtl/memscr_seq.sv
module memscr_seq
    import memscr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic renew_wr,
    input  logic init_wr,
    input  logic key_ack,
    input  logic init_ack,
    input  logic escalate,
    output logic key_req,
    output logic init_req,
    output logic renew_start,
    output logic key_done,
    output logic init_start,
    output logic init_fin,
    output logic dead
);
    seq_state_e state_q, state_d;
    logic       init_pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (renew_wr)     state_d = ST_KEY;
                else if (init_wr) state_d = ST_INIT;
            end
            ST_KEY: begin
                if (key_ack) state_d = (init_pend_q || init_wr) ? ST_INIT : ST_IDLE;
            end
            ST_INIT: begin
                if (init_ack) state_d = ST_IDLE;
            end
            ST_DEAD: state_d = ST_DEAD;
        endcase
        if (escalate) state_d = ST_DEAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            init_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != ST_KEY)
                init_pend_q <= 1'b0;
            else if (state_q == ST_IDLE)
                init_pend_q <= init_wr;
            else if (init_wr)
                init_pend_q <= 1'b1;
        end
    end

    always_comb begin
        key_req     = (state_q == ST_KEY);
        init_req    = (state_q == ST_INIT);
        dead        = (state_q == ST_DEAD);
        renew_start = (state_q == ST_IDLE) && renew_wr && !escalate;
        key_done    = (state_q == ST_KEY) && key_ack && !escalate;
        init_start  = (state_d == ST_INIT) && (state_q != ST_INIT);
        init_fin    = (state_q == ST_INIT) && init_ack && !escalate;
    end
endmodule

// File: rtl/memscr_regs.sv
module memscr_regs
    import memscr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              key_req,
    input  logic              key_ack,
    input  logic              key_seed_ok,
    output logic              init_req,
    input  logic              init_ack,
    input  logic              escalate,
    input  logic              err_bus_integ,
    input  logic              err_init_cnt,
    input  logic              err_readback,
    input  logic              err_mem_multibit,
    output logic              mem_block,
    output logic              fatal_alert,
    output logic [MB_W-1:0]   exec_en,
    output logic [MB_W-1:0]   readback_en
);
    localparam int ST_W = 8;

    logic              wr_en;
    logic [N_LOCK-1:0] lock_open;
    logic              renew_start, key_done, init_start, init_fin, dead;
    logic              renew_wr, init_wr;
    logic [ST_W-1:0]   status_q;
    logic [MB_W-1:0]   rot_q;
    logic              alert_test_q;
    logic              unused_wdata;

    assign wr_en        = req_valid && req_write;
    assign unused_wdata = ^req_wdata[DATA_W-1:MB_W] ^ dead;

    for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
        memscr_lock #(.MY_ADDR(LOCK_ADDR[g])) i_lock (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_addr  (req_addr),
            .wr_bit   (req_wdata[0]),
            .lock_open(lock_open[g])
        );
    end

    assign renew_wr = wr_en && req_addr == A_CTRL && lock_open[1] && req_wdata[0];
    assign init_wr  = wr_en && req_addr == A_CTRL && lock_open[1] && req_wdata[1];

    memscr_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .renew_wr   (renew_wr),
        .init_wr    (init_wr),
        .key_ack    (key_ack),
        .init_ack   (init_ack),
        .escalate   (escalate),
        .key_req    (key_req),
        .init_req   (init_req),
        .renew_start(renew_start),
        .key_done   (key_done),
        .init_start (init_start),
        .init_fin   (init_fin),
        .dead       (dead)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_en     <= MB_FALSE;
            readback_en <= MB_FALSE;
        end else begin
            if (wr_en && req_addr == A_XEN && lock_open[0])
                exec_en <= req_wdata[MB_W-1:0];
            if (wr_en && req_addr == A_REN && lock_open[2])
                readback_en <= req_wdata[MB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q     <= '0;
            rot_q        <= MB_FALSE;
            alert_test_q <= 1'b0;
        end else begin
            alert_test_q <= wr_en && req_addr == A_ALERT && req_wdata[0];
            status_q[0]  <= status_q[0] | err_bus_integ;
            status_q[1]  <= status_q[1] | err_init_cnt;
            status_q[6]  <= status_q[6] | err_readback;
            status_q[7]  <= status_q[7] | err_mem_multibit;
            if (init_start) status_q[5] <= 1'b0;
            else if (init_fin) status_q[5] <= 1'b1;
            if (escalate) begin
                status_q[2] <= 1'b1;
                status_q[3] <= 1'b0;
                status_q[4] <= 1'b0;
                rot_q       <= MB_FALSE;
            end else if (key_done) begin
                status_q[3] <= 1'b1;
                status_q[4] <= key_seed_ok;
                rot_q       <= MB_TRUE;
            end else begin
                if (renew_start) status_q[3] <= 1'b0;
                if (wr_en && req_addr == A_ROT && req_wdata[MB_W-1:0] == MB_TRUE)
                    rot_q <= MB_FALSE;
            end
        end
    end

    assign mem_block   = !status_q[3] || status_q[2];
    assign fatal_alert = alert_test_q || status_q[0] || status_q[1]
                         || status_q[6] || status_q[7];

    always_comb begin
        rsp_rdata = '0;
        case (req_addr)
            A_STATUS: rsp_rdata[ST_W-1:0] = status_q;
            A_XLOCK:  rsp_rdata[0]        = lock_open[0];
            A_XEN:    rsp_rdata[MB_W-1:0] = exec_en;
            A_CLOCK:  rsp_rdata[0]        = lock_open[1];
            A_ROT:    rsp_rdata[MB_W-1:0] = rot_q;
            A_RLOCK:  rsp_rdata[0]        = lock_open[2];
            A_REN:    rsp_rdata[MB_W-1:0] = readback_en;
            default:  rsp_rdata = '0;
        endcase
    end
endmodule

// File: rtl/memscr_regs_chk.sv
module memscr_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic key_req,
    input logic init_req,
    input logic mem_block,
    input logic fatal_alert,
    input logic escalate,
    input logic ctrl_open,
    input logic err_bus_integ,
    input logic err_init_cnt,
    input logic err_readback,
    input logic err_mem_multibit
);
    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_open) |-> !ctrl_open);

    p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_req && init_req));

    p_key_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_req |-> mem_block);

    p_dead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(escalate) |-> (mem_block && !key_req && !init_req));

    p_err_alert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bus_integ || err_init_cnt || err_readback || err_mem_multibit) |=> fatal_alert);
endmodule

bind memscr_regs memscr_regs_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .key_req         (key_req),
    .init_req        (init_req),
    .mem_block       (mem_block),
    .fatal_alert     (fatal_alert),
    .escalate        (escalate),
    .ctrl_open       (lock_open[1]),
    .err_bus_integ   (err_bus_integ),
    .err_init_cnt    (err_init_cnt),
    .err_readback    (err_readback),
    .err_mem_multibit(err_mem_multibit)
);

// File: tb/test_memscr_regs.sv
module test_memscr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        key_req, init_req, mem_block, fatal_alert;
    logic        key_ack = 1'b0, key_seed_ok = 1'b0, init_ack = 1'b0, escalate = 1'b0;
    logic        e_bus = 1'b0, e_cnt = 1'b0, e_rb = 1'b0, e_mem = 1'b0;
    logic [3:0]  exec_en, readback_en;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] exp_st;

    always #10 clk = ~clk;

    memscr_regs i_memscr_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .key_req(key_req), .key_ack(key_ack), .key_seed_ok(key_seed_ok),
        .init_req(init_req), .init_ack(init_ack), .escalate(escalate),
        .err_bus_integ(e_bus), .err_init_cnt(e_cnt), .err_readback(e_rb),
        .err_mem_multibit(e_mem), .mem_block(mem_block), .fatal_alert(fatal_alert),
        .exec_en(exec_en), .readback_en(readback_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        req_addr = a;
        #1;
        chk(tag, rsp_rdata, exp);
    endtask

    task automatic kack(input logic seed);
        @(negedge clk);
        key_ack = 1'b1; key_seed_ok = seed;
        @(negedge clk);
        key_ack = 1'b0; key_seed_ok = 1'b0;
    endtask

    task automatic iack();
        @(negedge clk);
        init_ack = 1'b1;
        @(negedge clk);
        init_ack = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd("R1 alert", 6'h00, 0);  rd("R1 status", 6'h04, 0);
        rd("R1 xlock", 6'h08, 1);  rd("R1 xen", 6'h0C, 9);
        rd("R1 clock", 6'h10, 1);  rd("R1 ctrl", 6'h14, 0);
        rd("R1 rot", 6'h18, 9);    rd("R1 rlock", 6'h1C, 1);
        rd("R1 ren", 6'h20, 9);
        chk("R1 mem_block", mem_block, 1);
        chk("R1 reqs", {key_req, init_req}, 0);
        // R11 reserved bits and read-only status
        wr(6'h04, 32'hFFFF_FFFF);
        rd("R11 status ro", 6'h04, 0);
        wr(6'h0C, 32'hFFFF_FFF5);
        rd("R11 reserved", 6'h0C, 5);
        rd("R11 unmapped", 6'h24, 0);
        // R2 enable sweeps while unlocked
        for (int v = 0; v < 16; v++) begin
            wr(6'h0C, v); rd("R2 xen sweep", 6'h0C, v);
            chk("R2 exec_en port", exec_en, v);
            wr(6'h20, v); rd("R2 ren sweep", 6'h20, v);
            chk("R2 readback_en port", readback_en, v);
        end
        wr(6'h0C, 9); wr(6'h20, 9);
        // R3 key request
        exp_st = 0;
        wr(6'h14, 1);
        chk("R3 key_req", key_req, 1);
        chk("R6 block pending", mem_block, 1);
        wr(6'h14, 1);  // R5 ignored while busy
        chk("R5 still key", {key_req, init_req}, 2'b10);
        kack(1'b1);
        exp_st = 32'h18;
        chk("R3 key_req drop", key_req, 0);
        rd("R3 status valid", 6'h04, exp_st);
        chk("R6 unblocked", mem_block, 0);
        rd("R7 rot set", 6'h18, 6);
        // R7 key-rotated sweep
        for (int v = 0; v < 16; v++) begin
            if (v != 6) begin
                wr(6'h18, v); rd("R7 rot ignore", 6'h18, 6);
            end
        end
        wr(6'h18, 6);
        rd("R7 rot clear", 6'h18, 9);
        for (int v = 0; v < 16; v++) begin
            wr(6'h18, v); rd("R7 rot stays false", 6'h18, 9);
        end
        // R4 both bits: key first, then init
        wr(6'h14, 3);
        chk("R4 key first", {key_req, init_req}, 2'b10);
        rd("R3 valid cleared", 6'h04, 32'h10);
        wr(6'h14, 2);  // R5 init already queued
        chk("R5 queued init ignored", {key_req, init_req}, 2'b10);
        kack(1'b0);
        chk("R4 init after key", {key_req, init_req}, 2'b01);
        rd("R4 status", 6'h04, 32'h08);
        rd("R7 rot again", 6'h18, 6);
        wr(6'h14, 1);  // R5 renew ignored during init
        chk("R5 renew during init", {key_req, init_req}, 2'b01);
        iack();
        chk("R12 init_req drop", init_req, 0);
        rd("R12 init done", 6'h04, 32'h28);
        // R12 init alone
        wr(6'h14, 2);
        chk("R12 init_req", {key_req, init_req}, 2'b01);
        rd("R12 done cleared", 6'h04, 32'h08);
        wr(6'h14, 2);
        chk("R5 init during init", init_req, 1);
        iack();
        rd("R12 done set", 6'h04, 32'h28);
        // R10 alert test
        wr(6'h00, 1);
        chk("R10 alert pulse", fatal_alert, 1);
        @(negedge clk);
        chk("R10 alert single", fatal_alert, 0);
        // R2 locks
        wr(6'h10, 1);  rd("R2 write1 keeps", 6'h10, 1);
        wr(6'h10, 0);  rd("R2 ctrl lock cleared", 6'h10, 0);
        wr(6'h10, 1);  rd("R2 lock sticky", 6'h10, 0);
        wr(6'h14, 3);
        chk("R2 ctrl locked", {key_req, init_req}, 0);
        rd("R2 status untouched", 6'h04, 32'h28);
        wr(6'h08, 0);  wr(6'h0C, 6);
        rd("R2 xen locked", 6'h0C, 9);
        wr(6'h1C, 0);  wr(6'h20, 6);
        rd("R2 ren locked", 6'h20, 9);
        // R9 errors
        exp_st = 32'h28;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            e_bus = (k == 0); e_cnt = (k == 1); e_rb = (k == 2); e_mem = (k == 3);
            @(negedge clk);
            e_bus = 0; e_cnt = 0; e_rb = 0; e_mem = 0;
            exp_st = exp_st | ((k == 0) ? 32'h01 : (k == 1) ? 32'h02 : (k == 2) ? 32'h40 : 32'h80);
            chk("R9 alert", fatal_alert, 1);
            rd("R9 status", 6'h04, exp_st);
        end
        repeat (3) @(negedge clk);
        chk("R9 alert held", fatal_alert, 1);
        // R8 escalation
        @(negedge clk); escalate = 1'b1;
        @(negedge clk); escalate = 1'b0;
        rd("R8 status", 6'h04, 32'hE7);
        rd("R8 rot", 6'h18, 9);
        chk("R8 block", mem_block, 1);
        repeat (4) @(negedge clk);
        chk("R8 block held", {mem_block, key_req, init_req}, 3'b100);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule